// File: doc/BRIEF.md
# Transmit Data Availability Gate

This block decides when a host should be told that device-to-host bytes are waiting in a transmit buffer. It does not report "not empty" directly. It holds the availability flag low while only a few bytes have arrived, so that the host is not called for each small dribble of data. The flag goes high on either of two conditions:

- enough bytes have built up to reach a hold threshold; or
- a hold timer has run out while bytes are still waiting.

The flag drops as soon as the buffer is empty.

The buffer supplies two signals. The first is its used-word count, which may lag behind the true fill level because it crosses a clock boundary. The second is an exact empty flag. The threshold test uses the count. Every empty/non-empty decision uses the exact flag. A free-running prescaler outside the block provides one-cycle tick strobes. The hold timer takes one step for every `TICKS_PER_STEP` ticks. A channel reset puts the gate back into its masked state.

Top module: `txq_avail_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, or `chan_rst` is high at a clock edge, `data_avail` is 0 after that edge and the hold timer returns to idle.
- R2: While masked, if the buffer is non-empty, `used_cnt` is below `HOLD_THRESH` and the timer has not expired, `data_avail` stays 0.
- R3: The hold timer advances only while it is armed. Armed means masked, `buf_empty` low, `used_cnt` below `HOLD_THRESH` and no channel reset. While armed, it steps once every `TICKS_PER_STEP` tick strobes, in the order idle, counting, expired. Expired is held.
- R4: While masked and `buf_empty` is low, a `used_cnt` of `HOLD_THRESH` or more sets `data_avail` to 1 on the next edge. The value exactly equal to `HOLD_THRESH` counts.
- R5: While masked and `buf_empty` is low, an expired timer sets `data_avail` to 1 on the edge after it expires. From an idle timer this takes 2*`TICKS_PER_STEP` ticks and then one clock.
- R6: `buf_empty` high at an edge makes `data_avail` 0 after that edge and returns the timer to idle, whatever the state was. A timer that is emptied partway through restarts from idle.
- R7: While unmasked, `used_cnt` has no effect. A stale low count, even 0, keeps `data_avail` at 1 for as long as `buf_empty` is low.
- R8: `data_avail` is a register output. It changes only at the clock edge that follows the input condition, never within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_rst | input | 1 | Synchronous channel reset, active high |
| tick | input | 1 | One-cycle strobe from the free-running prescaler |
| used_cnt | input | CNT_W | Used-word count of the transmit buffer, possibly stale |
| buf_empty | input | 1 | Exact empty flag of the transmit buffer |
| data_avail | output | 1 | Availability flag reported to the host |

## Verification
The assertions assume that `buf_empty` is exact. They do not assume that `used_cnt` agrees with `buf_empty`. This allows a count of 0 while the buffer is non-empty, and a large count while it is empty, and the stimulus applies both of these cases. The assertions also assume that `tick` is a strobe that may arrive in any cycle. The bench keeps each input steady across a stimulus window and places ticks one per two cycles. This means that timer steps can be counted exactly from the number of ticks applied.

// File: rtl/txq_avail_pkg.sv
// Package: shared state encodings for the transmit availability gate.
// Assumes nothing beyond being compiled before the modules that use it.
package txq_avail_pkg;

    typedef enum logic [1:0] {
        HS_IDLE     = 2'd0,
        HS_COUNTING = 2'd1,
        HS_EXPIRED  = 2'd2
    } hold_state_t;

    typedef enum logic {
        GS_MASKED   = 1'b0,
        GS_UNMASKED = 1'b1
    } gate_state_t;

endpackage

// File: rtl/txq_step_div.sv
// Module: txq_step_div
// Divides the prescaler tick strobes down to hold-timer steps. It emits one
// step for every TICKS_PER_STEP ticks that arrive while armed.
// Assumes: tick is a one-cycle strobe. Dropping arm discards any partial count.
module txq_step_div #(
    parameter int TICKS_PER_STEP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic tick,
    output logic step
);
    localparam int DW = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
    localparam logic [DW-1:0] LAST = DW'(TICKS_PER_STEP - 1);

    logic [DW-1:0] cnt;

    // Count ticks while armed; wrap at the last tick of a step.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // A step fires on the tick that completes a group.
    always_comb step = arm && tick && (cnt == LAST);

endmodule

// File: rtl/txq_hold_timer.sv
// Module: txq_hold_timer
// Three-state hold timer. It steps idle -> counting -> expired, one step per
// adv pulse, and then stays expired.
// Assumes: clr takes priority over adv. adv is only pulsed while armed.
module txq_hold_timer
    import txq_avail_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        adv,
    output hold_state_t state
);
    // Advance or clear the timer state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= HS_IDLE;
        end else if (adv) begin
            unique case (state)
                HS_IDLE:     state <= HS_COUNTING;
                HS_COUNTING: state <= HS_EXPIRED;
                default:     state <= HS_EXPIRED;
            endcase
        end
    end

endmodule

// File: rtl/txq_mask_fsm.sv
// Module: txq_mask_fsm
// Two-state availability gate. It unmasks when the buffer is non-empty and a
// release condition holds, and masks again on empty.
// Assumes: buf_empty is exact. release_ok is qualified elsewhere.
module txq_mask_fsm
    import txq_avail_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chan_rst,
    input  logic        buf_empty,
    input  logic        release_ok,
    output gate_state_t state
);
    // Masked/unmasked transitions; both resets force masked.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            state <= GS_MASKED;
        end else begin
            unique case (state)
                GS_MASKED:   if (!buf_empty && release_ok) state <= GS_UNMASKED;
                GS_UNMASKED: if (buf_empty) state <= GS_MASKED;
                default:     state <= GS_MASKED;
            endcase
        end
    end

endmodule

// File: rtl/txq_avail_gate.sv
// Module: txq_avail_gate (top)
// Decides when to advertise waiting transmit bytes to the host. It releases
// the flag on a fill threshold or on a hold timeout, and masks on empty.
// Assumes: used_cnt may be stale and is used only for the threshold test.
// buf_empty is exact. tick is a one-cycle prescaler strobe.
module txq_avail_gate
    import txq_avail_pkg::*;
#(
    parameter int CNT_W          = 13,
    parameter int HOLD_THRESH    = 32,
    parameter int TICKS_PER_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] used_cnt,
    input  logic             buf_empty,
    output logic             data_avail
);
    localparam logic [CNT_W-1:0] THR = CNT_W'(HOLD_THRESH);

    gate_state_t gate_st;
    hold_state_t hold_st;
    logic        at_thr;
    logic        armed;
    logic        step;
    logic        timer_clr;
    logic        release_ok;

    // Decode the threshold, arming, clearing and release conditions.
    always_comb begin
        at_thr     = (used_cnt >= THR);
        armed      = (gate_st == GS_MASKED) && !buf_empty && !at_thr && !chan_rst;
        timer_clr  = chan_rst || buf_empty;
        release_ok = at_thr || (hold_st == HS_EXPIRED);
    end

    txq_step_div #(.TICKS_PER_STEP(TICKS_PER_STEP)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (armed),
        .tick  (tick),
        .step  (step)
    );

    txq_hold_timer timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .adv   (step),
        .state (hold_st)
    );

    txq_mask_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_rst   (chan_rst),
        .buf_empty  (buf_empty),
        .release_ok (release_ok),
        .state      (gate_st)
    );

    // The output is the gate register, decoded without extra logic.
    always_comb data_avail = (gate_st == GS_UNMASKED);

endmodule

// File: rtl/txq_avail_gate_chk.sv
// Module: txq_avail_gate_chk
// Property checker for txq_avail_gate, bound into every instance.
// Assumes: the same parameters as the bound instance.
module txq_avail_gate_chk
    import txq_avail_pkg::*;
#(
    parameter int CNT_W       = 13,
    parameter int HOLD_THRESH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chan_rst,
    input logic [CNT_W-1:0] used_cnt,
    input logic             buf_empty,
    input logic             data_avail,
    input hold_state_t      hold_st
);
    localparam logic [CNT_W-1:0] THR = CNT_W'(HOLD_THRESH);

    // R1: a channel reset leaves the flag low
    a_r1_chan_rst_masks: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> !data_avail);

    // R6: an empty buffer leaves the flag low
    a_r6_empty_masks: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |=> !data_avail);

    // R4 / R5: a rise needs data plus threshold or expiry
    a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_avail) |-> $past(!buf_empty && !chan_rst &&
                                    (used_cnt >= THR || hold_st == HS_EXPIRED)));

    // R3: the timer moves forward only while armed
    a_r3_timer_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_st != $past(hold_st) && hold_st != HS_IDLE) |->
            $past(!data_avail && !buf_empty && !chan_rst && used_cnt < THR));

    // R3: expired is never reached straight from idle
    a_r3_step_order: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_st == HS_EXPIRED && $past(hold_st) != HS_EXPIRED) |->
            $past(hold_st) == HS_COUNTING);

    // R7: while unmasked only empty or a reset lowers the flag
    a_r7_hold_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (data_avail && !buf_empty && !chan_rst) |=> data_avail);

endmodule

bind txq_avail_gate txq_avail_gate_chk #(
    .CNT_W       (CNT_W),
    .HOLD_THRESH (HOLD_THRESH)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_rst   (chan_rst),
    .used_cnt   (used_cnt),
    .buf_empty  (buf_empty),
    .data_avail (data_avail),
    .hold_st    (hold_st)
);

// File: tb/txq_avail_gate_tb_top.sv
`timescale 1ns/1ps
// Bench for txq_avail_gate. It walks a vector table and then runs directed
// tests for reset, latency and exact tick counts.
module txq_avail_gate_tb_top;
    localparam int CNT_W = 13;
    localparam int THR   = 32;
    localparam int TPS   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chan_rst = 1'b0;
    logic             tick = 1'b0;
    logic [CNT_W-1:0] used_cnt = '0;
    logic             buf_empty = 1'b1;
    logic             data_avail;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    txq_avail_gate #(.CNT_W(CNT_W), .HOLD_THRESH(THR), .TICKS_PER_STEP(TPS)) dut_i (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .tick(tick),
        .used_cnt(used_cnt), .buf_empty(buf_empty), .data_avail(data_avail)
    );

    // Fields: chan_rst, buf_empty, used_cnt, tick count, expected flag.
    localparam int NV = 18;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 1'b1, 13'd0,  4'd0, 1'b0},  // R1 channel reset
        {1'b0, 1'b0, 13'd5,  4'd0, 1'b0},  // R2 dribble hidden
        {1'b0, 1'b0, 13'd5,  4'd4, 1'b0},  // R3 one step: counting
        {1'b0, 1'b0, 13'd5,  4'd4, 1'b1},  // R5 expired -> shown
        {1'b0, 1'b1, 13'd0,  4'd0, 1'b0},  // R6 empty masks
        {1'b0, 1'b0, 13'd40, 4'd0, 1'b1},  // R4 above threshold
        {1'b0, 1'b0, 13'd40, 4'd0, 1'b1},  // R7 held
        {1'b0, 1'b1, 13'd3,  4'd0, 1'b0},  // R6 empty with stale count
        {1'b0, 1'b0, 13'd32, 4'd0, 1'b1},  // R4 exactly threshold
        {1'b0, 1'b1, 13'd0,  4'd0, 1'b0},  // R6
        {1'b0, 1'b0, 13'd31, 4'd0, 1'b0},  // R2 one below threshold
        {1'b0, 1'b0, 13'd31, 4'd7, 1'b0},  // R3 one step plus partial
        {1'b0, 1'b1, 13'd31, 4'd0, 1'b0},  // R6 timer back to idle
        {1'b0, 1'b0, 13'd31, 4'd4, 1'b0},  // R6 restarted: only counting
        {1'b0, 1'b0, 13'd31, 4'd4, 1'b1},  // R5
        {1'b1, 1'b0, 13'd40, 4'd0, 1'b0},  // R1 chan_rst overrides
        {1'b0, 1'b0, 13'd40, 4'd0, 1'b1},  // R4 after channel reset
        {1'b0, 1'b0, 13'd0,  4'd0, 1'b1}   // R7 stale zero count ignored
    };

    task automatic check(input logic got, input logic exp, input string req);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: data_avail=%b expected %b", req, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(data_avail, 1'b0, "R1 reset state");
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            chan_rst  = VEC[v][19];
            buf_empty = VEC[v][18];
            used_cnt  = VEC[v][17:5];
            ticks(int'(VEC[v][4:1]));
            repeat (2) @(negedge clk);
            check(data_avail, VEC[v][0], $sformatf("R%0s vector %0d",
                  (v == 0 || v == 15) ? "1" : "x", v));
        end
        chan_rst = 1'b0;

        // R8: threshold release appears exactly one edge later
        @(negedge clk) begin buf_empty = 1'b1; used_cnt = '0; end
        repeat (2) @(negedge clk);
        buf_empty = 1'b0; used_cnt = 13'd50;
        #1 check(data_avail, 1'b0, "R8 no same-cycle change");
        @(negedge clk) check(data_avail, 1'b1, "R8 set one edge later");

        // R8: empty lowers it exactly one edge later
        buf_empty = 1'b1;
        #1 check(data_avail, 1'b1, "R8 no same-cycle drop");
        @(negedge clk) check(data_avail, 1'b0, "R6 cleared one edge later");

        // R5: exact tick count, 2*TPS-1 ticks keep it hidden
        buf_empty = 1'b0; used_cnt = 13'd2;
        ticks(2 * TPS - 1);
        repeat (2) @(negedge clk);
        check(data_avail, 1'b0, "R5 one tick short");
        ticks(1);
        check(data_avail, 1'b0, "R5 expiry edge: flag not yet set");
        @(negedge clk) check(data_avail, 1'b1, "R5 set after expiry");

        // R1: rst_n low clears an unmasked gate
        rst_n = 1'b0;
        @(negedge clk) check(data_avail, 1'b0, "R1 rst_n clears");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(data_avail, 1'b0, "R1 timer idle after reset");

        // R3: the timer did not run while at or above threshold
        used_cnt = 13'd60;
        @(negedge clk) check(data_avail, 1'b1, "R4 after reset");
        buf_empty = 1'b1;
        @(negedge clk);
        buf_empty = 1'b0; used_cnt = 13'd1;
        ticks(TPS);
        repeat (2) @(negedge clk);
        check(data_avail, 1'b0, "R3 single step does not release");

        finish_run();
    end
endmodule